// File: doc/BRIEF.md
# AEGIS-128 State Update Engine

This block keeps the 640-bit working state of the AEGIS-128 authenticated cipher as five 128-bit words and advances it by one full state update per clock cycle. Each update passes every word through one AES round that has no round-key addition, then folds each result into the next word around the ring. A message word is mixed into word 0. The surrounding datapath supplies message words and reads the five state words directly, so it can derive keystream or tag material outside this block.

A one-cycle start pulse loads the state from the key, the IV and two fixed constants built from Fibonacci numbers. The engine then runs ten updates on its own, feeding the latched key and key XOR IV in turn. While the engine is idle it shows `ready_o` high and applies one update in every cycle where `msg_valid_i` is high.

The controller has two states. IDLE is the reset state. In IDLE, start leads to INIT; a message strobe applies one update and stays in IDLE; with neither, the state holds and the engine stays in IDLE. INIT runs the ten initialization updates, then the last step leads back to IDLE.

Top module: `aegis_state_engine`

## Requirements
- R1: After reset all five state words are zero and `ready_o` is high.
- R2: In IDLE with `msg_valid_i` high and `start_i` low, the next state is S0' = S0 ^ Rnd(S4) ^ M and Si' = Si ^ Rnd(S(i-1)) for i = 1..4. Every term uses the state from before the update.
- R3: Rnd is a keyless AES round in this order: ShiftRows, then SubBytes, then MixColumns. Byte b of a word occupies bits [8b+7:8b], and byte 4c+r is row r of column c. ShiftRows takes output byte j from input byte {0,5,10,15,4,9,14,3,8,13,2,7,12,1,6,11}[j].
- R4: A start in IDLE loads S0 = K^IV, S1 = C1, S2 = C0, S3 = K^C0, S4 = K^C1. It then applies ten updates with message K, K^IV, K, K^IV, and so on. C0 holds bytes 0..15 = 00 01 01 02 03 05 08 0d 15 22 37 59 90 e9 79 62, and C1 holds db 3d 18 55 6d c2 2f f1 20 11 31 42 73 b5 28 dd.
- R5: `ready_o` falls in the cycle after an accepted start, stays low for exactly ten cycles, then rises.
- R6: While `ready_o` is low, `msg_valid_i`, `msg_i` and `start_i` have no effect on the state.
- R7: When `start_i` and `msg_valid_i` are both high in IDLE, start takes priority and the message is dropped.
- R8: In IDLE with neither `start_i` nor `msg_valid_i` high, the state words hold their values.
- R9: Key and IV are captured in the start cycle. Later changes on `key_i` and `iv_i` do not affect initialization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin load and initialization |
| key_i | input | 128 | Key K |
| iv_i | input | 128 | Initialization vector |
| msg_i | input | 128 | Message word for one update |
| msg_valid_i | input | 1 | Apply one update with `msg_i` |
| ready_o | output | 1 | Engine idle, accepts start or message |
| word0_o | output | 128 | State word S0 |
| word1_o | output | 128 | State word S1 |
| word2_o | output | 128 | State word S2 |
| word3_o | output | 128 | State word S3 |
| word4_o | output | 128 | State word S4 |

## Verification
A zero message on the all-zero reset state makes S1..S4 equal to the round of zero, which is 0x63 in every byte. This checks the S-box constant and the column mixing on uniform data before any random data is used. Back-to-back random message words, and strobes with gaps, separate correct chaining of the pre-update state from a ring that is shifted or that reads already-updated words. Initialization runs with random keys and IVs. One run holds a message strobe in the start cycle, keeps it high throughout, and toggles key and IV while busy. Only the correct priority, the correct capture and the correct K / K^IV alternation give the reference final state.

// File: rtl/aegis_pkg.sv
package aegis_pkg;

    localparam int WORD_W    = 128;
    localparam int NUM_WORDS = 5;
    localparam int BYTES_W   = WORD_W / 8;

    typedef logic [WORD_W-1:0]                 word_t;
    typedef logic [NUM_WORDS-1:0][WORD_W-1:0]  state_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_INIT = 1'b1
    } engine_state_e;

    // byte 0 sits in bits [7:0]
    localparam word_t FIB_C0 = 128'h6279e99059372215_0d08050302010100;
    localparam word_t FIB_C1 = 128'hdd28b57342311120_f12fc26d55183ddb;

    function automatic logic [7:0] gf_dbl(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) acc = acc ^ sh;
            sh = gf_dbl(sh);
        end
        return acc;
    endfunction

endpackage

// File: rtl/aegis_sbox.sv
module aegis_sbox
    import aegis_pkg::*;
(
    input  logic [7:0] in_b,
    output logic [7:0] out_b
);
    logic [7:0] inv_b;

    // inverse as x^254 = product of x^(2^k), k = 1..7
    always_comb begin
        logic [7:0] sq;
        logic [7:0] acc;
        sq  = in_b;
        acc = 8'h01;
        for (int k = 1; k < 8; k++) begin
            sq  = gf_mul(sq, sq);
            acc = gf_mul(acc, sq);
        end
        inv_b = acc;
    end

    assign out_b = inv_b
                 ^ {inv_b[6:0], inv_b[7]}
                 ^ {inv_b[5:0], inv_b[7:6]}
                 ^ {inv_b[4:0], inv_b[7:5]}
                 ^ {inv_b[3:0], inv_b[7:4]}
                 ^ 8'h63;
endmodule

// File: rtl/aegis_round.sv
module aegis_round
    import aegis_pkg::*;
(
    input  word_t in_w,
    output word_t out_w
);
    localparam int ROWS = 4;
    localparam int COLS = BYTES_W / ROWS;

    word_t shifted;
    word_t subbed;

    genvar gc, gr;
    generate
        for (gc = 0; gc < COLS; gc++) begin : g_col
            for (gr = 0; gr < ROWS; gr++) begin : g_row
                localparam int DST = gc * ROWS + gr;
                localparam int SRC = ((gc + gr) % COLS) * ROWS + gr;
                assign shifted[DST*8 +: 8] = in_w[SRC*8 +: 8];
                aegis_sbox u_sbox (
                    .in_b  (shifted[DST*8 +: 8]),
                    .out_b (subbed[DST*8 +: 8])
                );
            end

            for (gr = 0; gr < ROWS; gr++) begin : g_mix
                localparam int B0 = gc * ROWS + gr;
                localparam int B1 = gc * ROWS + (gr + 1) % ROWS;
                localparam int B2 = gc * ROWS + (gr + 2) % ROWS;
                localparam int B3 = gc * ROWS + (gr + 3) % ROWS;
                assign out_w[B0*8 +: 8] = gf_dbl(subbed[B0*8 +: 8])
                                        ^ gf_dbl(subbed[B1*8 +: 8]) ^ subbed[B1*8 +: 8]
                                        ^ subbed[B2*8 +: 8]
                                        ^ subbed[B3*8 +: 8];
            end
        end
    endgenerate
endmodule

// File: rtl/aegis_update.sv
module aegis_update
    import aegis_pkg::*;
(
    input  state_t cur_s,
    input  word_t  msg_w,
    output state_t nxt_s
);
    state_t rnd_s;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_WORDS; gi++) begin : g_word
            localparam int PREV = (gi + NUM_WORDS - 1) % NUM_WORDS;
            aegis_round u_round (
                .in_w  (cur_s[PREV]),
                .out_w (rnd_s[gi])
            );
            if (gi == 0) begin : g_head
                assign nxt_s[gi] = cur_s[gi] ^ rnd_s[gi] ^ msg_w;
            end else begin : g_body
                assign nxt_s[gi] = cur_s[gi] ^ rnd_s[gi];
            end
        end
    endgenerate
endmodule

// File: rtl/aegis_state_engine.sv
module aegis_state_engine
    import aegis_pkg::*;
#(
    parameter int INIT_PAIRS = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [127:0] key_i,
    input  logic [127:0] iv_i,
    input  logic [127:0] msg_i,
    input  logic         msg_valid_i,
    output logic         ready_o,
    output logic [127:0] word0_o,
    output logic [127:0] word1_o,
    output logic [127:0] word2_o,
    output logic [127:0] word3_o,
    output logic [127:0] word4_o
);
    localparam int INIT_STEPS = 2 * INIT_PAIRS;
    localparam int STEP_W     = $clog2(INIT_STEPS + 1);

    engine_state_e fsm_q, fsm_d;
    logic [STEP_W-1:0] step_q, step_d;
    word_t  key_q, key_d;
    word_t  kiv_q, kiv_d;
    state_t words_q, words_d;
    state_t words_upd;
    state_t words_load;
    word_t  upd_msg;

    always_comb begin
        words_load[0] = key_i ^ iv_i;
        words_load[1] = FIB_C1;
        words_load[2] = FIB_C0;
        words_load[3] = key_i ^ FIB_C0;
        words_load[4] = key_i ^ FIB_C1;
    end

    // even steps feed K, odd steps feed K^IV
    assign upd_msg = (fsm_q == ST_INIT) ? (step_q[0] ? kiv_q : key_q) : msg_i;

    aegis_update u_update (
        .cur_s (words_q),
        .msg_w (upd_msg),
        .nxt_s (words_upd)
    );

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q   <= ST_IDLE;
            step_q  <= '0;
            key_q   <= '0;
            kiv_q   <= '0;
            words_q <= '0;
        end else begin
            fsm_q   <= fsm_d;
            step_q  <= step_d;
            key_q   <= key_d;
            kiv_q   <= kiv_d;
            words_q <= words_d;
        end
    end

    // next state and datapath selection
    always_comb begin
        fsm_d   = fsm_q;
        step_d  = step_q;
        key_d   = key_q;
        kiv_d   = kiv_q;
        words_d = words_q;
        unique case (fsm_q)
            ST_IDLE: begin
                if (start_i) begin
                    fsm_d   = ST_INIT;
                    step_d  = '0;
                    key_d   = key_i;
                    kiv_d   = key_i ^ iv_i;
                    words_d = words_load;
                end else if (msg_valid_i) begin
                    words_d = words_upd;
                end
            end
            ST_INIT: begin
                words_d = words_upd;
                step_d  = step_q + 1'b1;
                if (step_q == STEP_W'(INIT_STEPS - 1)) begin
                    fsm_d = ST_IDLE;
                end
            end
            default: fsm_d = ST_IDLE;
        endcase
    end

    // output process
    always_comb begin
        ready_o = (fsm_q == ST_IDLE);
        word0_o = words_q[0];
        word1_o = words_q[1];
        word2_o = words_q[2];
        word3_o = words_q[3];
        word4_o = words_q[4];
    end
endmodule

// File: rtl/aegis_state_engine_chk.sv
module aegis_state_engine_chk
    import aegis_pkg::*;
#(
    parameter int INIT_PAIRS = 5
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [127:0] key_i,
    input logic         msg_valid_i,
    input logic         ready_o,
    input logic [127:0] word0_o,
    input logic [127:0] word1_o,
    input logic [127:0] word2_o,
    input logic [127:0] word3_o,
    input logic [127:0] word4_o
);
    localparam int INIT_STEPS = 2 * INIT_PAIRS;

    logic [7:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)            busy_cnt <= '0;
        else if (ready_o)      busy_cnt <= '0;
        else if (busy_cnt != 8'hff) busy_cnt <= busy_cnt + 8'd1;
    end

    p_start_drops_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && start_i) |=> !ready_o);

    p_busy_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> (busy_cnt < 8'(INIT_STEPS)));

    p_busy_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> (busy_cnt == 8'(INIT_STEPS)));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !start_i && !msg_valid_i) |=>
            ($stable(word0_o) && $stable(word1_o) && $stable(word2_o)
             && $stable(word3_o) && $stable(word4_o)));

    p_init_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && start_i) |=>
            (word1_o == FIB_C1 && word2_o == FIB_C0
             && word3_o == ($past(key_i) ^ FIB_C0)
             && word4_o == ($past(key_i) ^ FIB_C1)));
endmodule

bind aegis_state_engine aegis_state_engine_chk #(.INIT_PAIRS(INIT_PAIRS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .key_i       (key_i),
    .msg_valid_i (msg_valid_i),
    .ready_o     (ready_o),
    .word0_o     (word0_o),
    .word1_o     (word1_o),
    .word2_o     (word2_o),
    .word3_o     (word3_o),
    .word4_o     (word4_o)
);

// File: tb/aegis_state_engine_tb_top.sv
`timescale 1ns/1ps
module aegis_state_engine_tb_top;

    typedef logic [4:0][127:0] mstate_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [127:0] key_i = '0;
    logic [127:0] iv_i = '0;
    logic [127:0] msg_i = '0;
    logic         msg_valid_i = 1'b0;
    logic         ready_o;
    logic [127:0] word0_o, word1_o, word2_o, word3_o, word4_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] sb [256];
    mstate_t model;

    always #4 clk = ~clk;

    aegis_state_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .key_i(key_i), .iv_i(iv_i),
        .msg_i(msg_i), .msg_valid_i(msg_valid_i), .ready_o(ready_o),
        .word0_o(word0_o), .word1_o(word1_o), .word2_o(word2_o),
        .word3_o(word3_o), .word4_o(word4_o)
    );

    localparam logic [127:0] K_C0 = 128'h6279e99059372215_0d08050302010100;
    localparam logic [127:0] K_C1 = 128'hdd28b57342311120_f12fc26d55183ddb;
    localparam int SR_TAB [16] = '{0,5,10,15,4,9,14,3,8,13,2,7,12,1,6,11};

    function automatic logic [7:0] m_xt(input logic [7:0] a);
        m_xt = a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
    endfunction

    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 0;
        logic [7:0] x = a;
        logic [7:0] y = b;
        while (y != 0) begin
            if (y[0]) r ^= x;
            x = m_xt(x);
            y = y >> 1;
        end
        return r;
    endfunction

    function automatic logic [7:0] m_rotl(input logic [7:0] a, input int n);
        return (a << n) | (a >> (8 - n));
    endfunction

    function automatic logic [127:0] m_round(input logic [127:0] w);
        logic [7:0] t [16];
        logic [127:0] o;
        for (int j = 0; j < 16; j++) t[j] = sb[w[SR_TAB[j]*8 +: 8]];
        for (int c = 0; c < 4; c++) begin
            logic [7:0] a0, a1, a2, a3;
            a0 = t[4*c]; a1 = t[4*c+1]; a2 = t[4*c+2]; a3 = t[4*c+3];
            o[(4*c)*8   +: 8] = m_mul(a0,2) ^ m_mul(a1,3) ^ a2 ^ a3;
            o[(4*c+1)*8 +: 8] = a0 ^ m_mul(a1,2) ^ m_mul(a2,3) ^ a3;
            o[(4*c+2)*8 +: 8] = a0 ^ a1 ^ m_mul(a2,2) ^ m_mul(a3,3);
            o[(4*c+3)*8 +: 8] = m_mul(a0,3) ^ a1 ^ a2 ^ m_mul(a3,2);
        end
        return o;
    endfunction

    function automatic mstate_t m_update(input mstate_t s, input logic [127:0] m);
        mstate_t n;
        n[0] = s[0] ^ m_round(s[4]) ^ m;
        for (int i = 1; i < 5; i++) n[i] = s[i] ^ m_round(s[i-1]);
        return n;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic chk_bit(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        mstate_t act;
        act = {word4_o, word3_o, word2_o, word1_o, word0_o};
        n_cmp++;
        if (act !== model) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, model);
        end
    endtask

    // one message update, called at a negedge
    task automatic apply_msg(input logic [127:0] m, input string req);
        msg_i = m;
        msg_valid_i = 1'b1;
        @(negedge clk);
        msg_valid_i = 1'b0;
        model = m_update(model, m);
        chk_state(req);
    endtask

    task automatic run_init(input logic [127:0] k, input logic [127:0] v,
                            input bit disturb, input string req);
        int busy;
        key_i = k; iv_i = v; start_i = 1'b1;
        if (disturb) begin msg_valid_i = 1'b1; msg_i = rnd128(); end
        @(negedge clk);
        start_i = 1'b0;
        model[0] = k ^ v; model[1] = K_C1; model[2] = K_C0;
        model[3] = k ^ K_C0; model[4] = k ^ K_C1;
        chk_state("R4 load");
        busy = 0;
        while (!ready_o && busy < 20) begin
            busy++;
            if (disturb) begin
                key_i = rnd128(); iv_i = rnd128(); msg_i = rnd128();
                start_i = busy[0];
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        msg_valid_i = 1'b0;
        chk_int("R5 busy length", busy, 10);
        for (int p = 0; p < 5; p++) begin
            model = m_update(model, k);
            model = m_update(model, k ^ v);
        end
        chk_state(req);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240917));
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 0;
            for (int y = 1; y < 256; y++)
                if (m_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            sb[x] = inv ^ m_rotl(inv,1) ^ m_rotl(inv,2) ^ m_rotl(inv,3) ^ m_rotl(inv,4) ^ 8'h63;
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        model = '0;
        chk_bit("R1 ready after reset", ready_o, 1'b1);
        chk_state("R1 zero state");

        repeat (3) @(negedge clk);
        chk_state("R8 idle hold");

        // zero message on zero state: S1..S4 become 0x63 in every byte
        apply_msg('0, "R3 round of zero");
        chk_bit("R3 S1 all 0x63", word1_o == {16{8'h63}}, 1'b1);

        for (int i = 0; i < 12; i++) apply_msg(rnd128(), "R2 back-to-back update");

        run_init(rnd128(), rnd128(), 1'b0, "R4 init result");
        run_init(128'h0, 128'hffffffff_ffffffff_ffffffff_ffffffff, 1'b0, "R4 init zero key");

        // start with simultaneous strobe, disturbed inputs while busy
        run_init(rnd128(), rnd128(), 1'b1, "R6 R7 R9 init ignores traffic");

        for (int i = 0; i < 30; i++) begin
            if ($urandom_range(0, 2) != 0) apply_msg(rnd128(), "R2 gapped update");
            else begin
                msg_i = rnd128();
                @(negedge clk);
                chk_state("R8 hold with gap");
            end
        end
        chk_bit("R5 ready idle", ready_o, 1'b1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule